// File: doc/BRIEF.md
# Nibble-Split Serial Command Framer

This block turns one write request at a time into a framed serial transfer for a graphic display controller reached over a three-wire link. The link has a select, a serial clock and a data line. A request is one command byte, one data byte, or a burst of up to `MAX_BYTES` data bytes. The requester hands the request over through a valid/ready handshake and then waits for the single-cycle `done` pulse.

Every frame starts with a header byte. The header has five ones in its top bits, then the direction flag (always 0 for a write), then the register-select flag, then a zero. Each payload byte is sent as two transfer bytes. The first carries the upper nibble and the second carries the lower nibble, and in both the nibble sits in the top four bits with four zeros below it. A full 16-byte burst is therefore one header and 32 nibble bytes, 33 transfer bytes in all. The serial clock half-period is `HALF_DIV` system clock cycles.

Top module: `nib_frame_tx`

## Requirements
- R1: The first transfer byte of each frame is 8'hF8 when `req_rs` is 0 and 8'hFA when `req_rs` is 1. Bit 2 (direction) is always 0 and bit 1 equals `req_rs`.
- R2: Every payload byte P is sent as {P[7:4],4'h0} followed by {P[3:0],4'h0}.
- R3: A request carries `req_last_idx`+1 payload bytes, with `req_last_idx` being the byte count minus one on 4 bits. The frame holds one header and 2*(`req_last_idx`+1) nibble bytes, so 8*(1+2*(`req_last_idx`+1)) bits and 33 transfer bytes for a 16-byte burst.
- R4: Payload bytes go out in ascending lane order. Lane 0 (`req_bytes[7:0]`) is sent first and lane k is `req_bytes[8k+7:8k]`.
- R5: Bits go out MSB first. `link_sclk` idles low. `link_mosi` changes only together with a falling edge of `link_sclk` and is stable across each rising edge, where the receiver samples.
- R6: Each high or low phase of `link_sclk` lasts exactly `HALF_DIV` clock cycles.
- R7: `link_cs` (active high) rises one cycle after a handshake and stays high without a gap until the last falling serial clock edge of the frame. It then drops and stays low for at least one cycle before the next frame.
- R8: `req_ready` is high when the block is idle and low for the whole time `link_cs` is high.
- R9: `done` is a one-cycle pulse in the first cycle with `link_cs` low. It comes 2*`HALF_DIV`*(frame bits) cycles after the handshake edge.
- R10: During and right after reset, `link_cs`, `link_sclk`, `link_mosi` and `done` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle and able to take a request |
| req_rs | input | 1 | Register-select flag: 0 command, 1 display data |
| req_last_idx | input | $clog2(MAX_BYTES) | Payload byte count minus one |
| req_bytes | input | MAX_BYTES*8 | Payload lanes, lane 0 in the low byte |
| link_cs | output | 1 | Frame select, high for the whole frame |
| link_sclk | output | 1 | Serial clock, idle low |
| link_mosi | output | 1 | Serial data, MSB first |
| done | output | 1 | One-cycle pulse when a frame ends |

## Verification
All timing is counted from the clock edge that completes the handshake. `link_cs` and the first header bit appear one cycle after that edge. The serial clock toggles every `HALF_DIV` cycles after that, and `done` is due exactly 2*`HALF_DIV`*(frame bits) cycles after the handshake edge. The driver records the handshake cycle and queues the expected transfer bytes and the expected `done` cycle. The monitor samples on the falling system clock edge, shifts in `link_mosi` only in samples where `link_sclk` has just risen, and compares `done` against the queued cycle number with no tolerance.

// File: rtl/nft_pkg.sv
package nft_pkg;

    localparam int          XFER_BITS = 8;
    localparam int          BCNT_W    = $clog2(XFER_BITS);
    localparam logic [7:0]  SYNC_BASE = 8'hF8;
    localparam int          DIR_POS   = 2;
    localparam int          SEL_POS   = 1;

    typedef enum logic [0:0] {
        ST_IDLE,
        ST_SHIFT
    } fsm_t;

    typedef struct packed {
        logic [XFER_BITS-1:0] sh;
        logic [BCNT_W-1:0]    left;
    } shreg_t;

    // Header byte: five ones, direction (write = 0), register select, zero.
    function automatic logic [7:0] sync_byte(input logic rs);
        logic [7:0] b;
        b          = SYNC_BASE;
        b[DIR_POS] = 1'b0;
        b[SEL_POS] = rs;
        return b;
    endfunction

    // One half of a payload byte, nibble placed in the upper four bits.
    function automatic logic [7:0] nibble_xfer(input logic [7:0] pb, input logic low);
        return low ? {pb[3:0], 4'h0} : {pb[7:4], 4'h0};
    endfunction

endpackage

// File: rtl/nft_halfclk.sv
module nft_halfclk #(
    parameter int HALF_DIV = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int             CW  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0]  TOP = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (cnt == TOP)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = run && (cnt == TOP);

endmodule

// File: rtl/nft_expander.sv
module nft_expander import nft_pkg::*; #(
    parameter int MAX_BYTES = 16,
    parameter int IW        = $clog2(2 * MAX_BYTES + 1)
) (
    input  logic [MAX_BYTES*8-1:0] payload,
    input  logic [IW-1:0]          idx,
    output logic [7:0]             xbyte
);
    localparam int SW = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1;

    logic [7:0]    lane [MAX_BYTES];
    logic [IW-1:0] j;
    logic [SW-1:0] sel;

    for (genvar g = 0; g < MAX_BYTES; g++) begin : g_lane
        assign lane[g] = payload[g*8 +: 8];
    end

    // Transfer index 1 is the upper nibble of lane 0, index 2 its lower nibble, ...
    assign j     = idx - 1'b1;
    assign sel   = SW'(j >> 1);
    assign xbyte = nibble_xfer(lane[sel], j[0]);

endmodule

// File: rtl/nft_shifter.sv
module nft_shifter import nft_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       shift,
    input  logic [7:0] din,
    output logic       msb,
    output logic       last
);
    shreg_t st;

    always_ff @(posedge clk) begin
        if (rst)
            st <= '0;
        else if (load)
            st <= '{sh: din, left: BCNT_W'(XFER_BITS - 1)};
        else if (shift)
            st <= '{sh: {st.sh[XFER_BITS-2:0], 1'b0}, left: st.left - 1'b1};
    end

    assign msb  = st.sh[XFER_BITS-1];
    assign last = (st.left == '0);

endmodule

// File: rtl/nib_frame_tx.sv
module nib_frame_tx import nft_pkg::*; #(
    parameter int   HALF_DIV  = 2,
    parameter int   MAX_BYTES = 16,
    localparam int  LW        = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
    localparam int  IW        = $clog2(2 * MAX_BYTES + 1),
    localparam int  PW        = MAX_BYTES * 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    output logic          req_ready,
    input  logic          req_rs,
    input  logic [LW-1:0] req_last_idx,
    input  logic [PW-1:0] req_bytes,
    output logic          link_cs,
    output logic          link_sclk,
    output logic          link_mosi,
    output logic          done
);
    fsm_t          state;
    logic          cs_q, sclk_q, done_q;
    logic [LW-1:0] last_q;
    logic [PW-1:0] pay_q;
    logic [IW-1:0] xi_q;

    logic          tick, accept, fall, lastbit, at_end, msb;
    logic          sh_load, sh_shift;
    logic [IW-1:0] final_idx, next_idx;
    logic [7:0]    next_byte, sh_din;

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign fall      = tick && sclk_q;
    assign final_idx = IW'({last_q, 1'b0}) + IW'(2);
    assign next_idx  = xi_q + 1'b1;
    assign at_end    = (xi_q == final_idx);

    nft_halfclk #(.HALF_DIV(HALF_DIV)) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_SHIFT),
        .tick (tick)
    );

    nft_expander #(.MAX_BYTES(MAX_BYTES), .IW(IW)) u_exp (
        .payload (pay_q),
        .idx     (next_idx),
        .xbyte   (next_byte)
    );

    assign sh_load  = accept || (fall && lastbit && !at_end);
    assign sh_shift = fall && !lastbit;
    assign sh_din   = accept ? sync_byte(req_rs) : next_byte;

    nft_shifter u_sh (
        .clk   (clk),
        .rst   (rst),
        .load  (sh_load),
        .shift (sh_shift),
        .din   (sh_din),
        .msb   (msb),
        .last  (lastbit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cs_q   <= 1'b0;
            sclk_q <= 1'b0;
            done_q <= 1'b0;
            last_q <= '0;
            pay_q  <= '0;
            xi_q   <= '0;
        end else begin
            done_q <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state  <= ST_SHIFT;
                        cs_q   <= 1'b1;
                        last_q <= req_last_idx;
                        pay_q  <= req_bytes;
                        xi_q   <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (tick) begin
                        sclk_q <= !sclk_q;
                        if (sclk_q && lastbit) begin
                            if (at_end) begin
                                state  <= ST_IDLE;
                                cs_q   <= 1'b0;
                                done_q <= 1'b1;
                            end else begin
                                xi_q <= next_idx;
                            end
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign link_cs   = cs_q;
    assign link_sclk = sclk_q;
    assign link_mosi = cs_q & msb;
    assign done      = done_q;

endmodule

// File: rtl/nft_checker.sv
module nft_checker #(
    parameter int HALF_DIV = 2
) (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ready,
    input logic cs,
    input logic sclk,
    input logic mosi,
    input logic done
);
    logic [15:0] gap_q;
    logic        sclk_prev_q;

    always_ff @(posedge clk) begin
        if (rst || !cs)
            gap_q <= '0;
        else if (sclk != sclk_prev_q)
            gap_q <= 16'd1;
        else
            gap_q <= gap_q + 16'd1;
        sclk_prev_q <= rst ? 1'b0 : sclk;
    end

    assert_sclk_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !cs |-> !sclk);

    assert_mosi_on_fall_R5: assert property (@(posedge clk) disable iff (rst)
        (cs && $past(cs) && !$stable(mosi)) |-> $fell(sclk));

    assert_half_period_R6: assert property (@(posedge clk) disable iff (rst)
        (cs && (sclk != sclk_prev_q)) |-> (gap_q == 16'(HALF_DIV)));

    assert_cs_start_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(cs) |-> $past(req_valid && req_ready));

    assert_cs_end_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(cs) |-> done);

    assert_busy_R8: assert property (@(posedge clk) disable iff (rst)
        cs |-> !req_ready);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> (!cs && $past(cs)));

endmodule

bind nib_frame_tx nft_checker #(.HALF_DIV(HALF_DIV)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .cs        (link_cs),
    .sclk      (link_sclk),
    .mosi      (link_mosi),
    .done      (done)
);

// File: tb/tb_nib_frame_tx.sv
module tb_nib_frame_tx;
    localparam int HALF = 2;
    localparam int MAXB = 16;
    localparam int LW   = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic            req_valid = 1'b0;
    logic            req_ready;
    logic            req_rs = 1'b0;
    logic [LW-1:0]   req_last_idx = '0;
    logic [MAXB*8-1:0] req_bytes = '0;
    logic            link_cs, link_sclk, link_mosi, done;

    nib_frame_tx #(.HALF_DIV(HALF), .MAX_BYTES(MAXB)) dut (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_rs       (req_rs),
        .req_last_idx (req_last_idx),
        .req_bytes    (req_bytes),
        .link_cs      (link_cs),
        .link_sclk    (link_sclk),
        .link_mosi    (link_mosi),
        .done         (done)
    );

    int     n_chk = 0;
    int     n_bad = 0;
    longint cyc   = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    longint     due_q[$];
    int         bits_q[$];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Driver: queue the expected transfer bytes and done cycle, then hand over.
    task automatic send(input logic rs, input int nbytes, input logic [MAXB*8-1:0] pay,
                        input string tag);
        logic [7:0] b;
        while (!req_ready) @(negedge clk);
        exp_q.push_back(rs ? 8'hFA : 8'hF8);
        tag_q.push_back("R1 header");
        for (int i = 0; i < nbytes; i++) begin
            b = pay[i*8 +: 8];
            exp_q.push_back({b[7:4], 4'h0}); tag_q.push_back(tag);
            exp_q.push_back({b[3:0], 4'h0}); tag_q.push_back(tag);
        end
        bits_q.push_back(8 * (1 + 2 * nbytes));
        req_rs       = rs;
        req_last_idx = LW'(nbytes - 1);
        req_bytes    = pay;
        req_valid    = 1'b1;
        @(negedge clk);
        due_q.push_back(cyc + 2 * HALF * 8 * (1 + 2 * nbytes));
        req_valid    = 1'b0;
    endtask

    // Monitor
    logic       prev_sclk = 1'b0;
    logic       prev_cs   = 1'b0;
    logic       low_mosi  = 1'b0;
    logic [7:0] acc       = '0;
    int         bits = 0, gap = 0, bad_half = 0, bad_hold = 0, bad_busy = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (link_cs) begin
                if (req_ready) bad_busy++;
                if (link_sclk != prev_sclk) begin
                    if (gap != HALF) bad_half++;
                    gap = 1;
                end else begin
                    gap++;
                end
                if (link_sclk && !prev_sclk) begin
                    if (link_mosi != low_mosi) bad_hold++;
                    acc = {acc[6:0], link_mosi};
                    bits++;
                    if (bits % 8 == 0) begin
                        if (exp_q.size() == 0)
                            chk(1'b0, "R3 extra transfer byte", acc, 0);
                        else begin
                            logic [7:0] e;
                            string      t;
                            e = exp_q.pop_front();
                            t = tag_q.pop_front();
                            chk(acc == e, {t, " / R5 msb-first byte"}, acc, e);
                        end
                    end
                end
                if (!link_sclk) low_mosi = link_mosi;
            end else begin
                gap = 0;
                if (prev_cs && !done) chk(1'b0, "R7 select dropped without done", 0, 1);
            end
            if (done) begin
                longint ed;
                int     eb;
                chk(!link_cs, "R9 select low with done", link_cs, 0);
                chk(req_ready, "R8 ready back at done", req_ready, 1);
                ed = (due_q.size() != 0) ? due_q.pop_front() : -1;
                chk(cyc == ed, "R9 done cycle", cyc, ed);
                eb = (bits_q.size() != 0) ? bits_q.pop_front() : -1;
                chk(bits == eb, "R3 frame bit count", bits, eb);
                chk(bad_half == 0, "R6 sclk phase length errors", bad_half, 0);
                chk(bad_hold == 0, "R5 mosi moved at rising edge", bad_hold, 0);
                chk(bad_busy == 0, "R8 ready high while selected", bad_busy, 0);
                bits = 0; bad_half = 0; bad_hold = 0; bad_busy = 0;
            end
            prev_sclk = link_sclk;
            prev_cs   = link_cs;
        end
    end

    initial begin
        logic [MAXB*8-1:0] p;
        repeat (3) @(negedge clk);
        chk(!link_cs,   "R10 cs in reset",   link_cs,   0);
        chk(!link_sclk, "R10 sclk in reset", link_sclk, 0);
        chk(!link_mosi, "R10 mosi in reset", link_mosi, 0);
        chk(!done,      "R10 done in reset", done,      0);
        chk(req_ready,  "R10 ready in reset", req_ready, 1);
        rst = 1'b0;
        @(negedge clk);
        chk(!link_cs && req_ready, "R10 idle after reset", link_cs, 0);

        p = '0; p[7:0] = 8'h30;
        send(1'b0, 1, p, "R2 command nibble");
        p = '0; p[7:0] = 8'hA5;
        send(1'b1, 1, p, "R2 data nibble");
        for (int i = 0; i < MAXB; i++) p[i*8 +: 8] = 8'(i * 37 + 11);
        send(1'b1, MAXB, p, "R4 burst lane order");
        p = '0; p[23:0] = 24'hC3_7E_01;
        send(1'b0, 3, p, "R3 short burst");
        p = '0; p[15:0] = 16'hFF_00;
        send(1'b1, 2, p, "R2 back-to-back first");
        p = '0; p[7:0] = 8'h0C;
        send(1'b0, 1, p, "R7 back-to-back second");

        while (due_q.size() != 0) @(negedge clk);
        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R3 no bytes left unsent", exp_q.size(), 0);
        chk(!link_cs && !link_sclk, "R7 link idle at end", link_cs, 0);
        chk(req_ready, "R8 ready idle at end", req_ready, 1);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (60000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R9 watchdog: frames never completed");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule